// File: doc/BRIEF.md
# Pipelined Context-Adaptive Binary Arithmetic Coder

This block is the arithmetic-coding core of a video entropy encoder. It takes one binary symbol (a bin) per clock, each tagged either with a context number or as a bypass bin. It keeps the coder state: a 9-bit interval width (range) and a 10-bit interval base (low). Each context holds a 6-bit probability state and a most-probable-symbol (MPS) bit. For every bin, the block emits the renormalized low, the shift count, and the raw bits pushed out of low. A separate bit generator resolves carries and pending bits from these values.

The work is split into four stages so that a new bin can enter every cycle:

1. Read the context entry.
2. Fetch all four least-probable-symbol (LPS) width candidates and both successor states for that entry's probability state.
3. Pick the candidate with range bits [7:6], update and renormalize range, and write the context back.
4. Update and renormalize low.

A context written in stage 2 is passed forward to stages 0 and 1, so bins that reuse a context back to back see the fresh entry. When the consumer holds off the output, the whole pipeline stops in place.

Top module: `cabac_pipe_coder`

## Requirements
- R1: While in reset and right after it, `out_valid` is 0 and `in_ready` is 1. The coder starts with range 510 and low 0. Every context starts with state 0 and MPS 0.
- R2: When the output is not stalled, one bin is accepted per cycle and results leave in acceptance order. A result appears after the fourth rising edge, counting the edge that accepted the bin.
- R3: The LPS width is chosen as follows. For a context-coded bin with state s, let q = range[7:6]. The LPS width is floor(p_s*(288+64q)/65536), where p_0 = 32768 and p_s = floor(p_(s-1)*62206/65536). An MPS bin (bin equals the stored MPS) sets range to range minus the LPS width, then renormalizes.
- R4: Context update and LPS coding work as follows.
  - An MPS bin moves the state to min(s+1, 62).
  - An LPS bin sets range to the LPS width and adds (range minus LPS width) to low.
  - An LPS bin moves the state to s - floor((s+3)/4). At state 0 it also inverts the MPS.
- R5: For a context-coded bin, wide = (low + addend) shifted left by the shift count. `out_low` = wide mod 1024, and this value becomes the new low.
- R6: A bypass bin leaves range and all contexts unchanged. It reports shift 1 and uses wide = 2*low + (bin ? range : 0).
- R7: For a context-coded bin, the shift count equals the number of leading zeros of the 9-bit range before renormalization. `out_range` is always in [256, 511].
- R8: `out_bits` = floor(wide/1024) as an 8-bit value, and it is below 2^(shift+1).
- R9: A context-coded bin that reuses the context of either of the two bins accepted just before it is coded with that context's updated entry.
- R10: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A bin is offered |
| in_ready | output | 1 | The bin is taken on this edge |
| in_bypass | input | 1 | 1: equiprobable bin, 0: context-coded |
| in_ctx | input | CTX_W | Context number for a context-coded bin |
| in_bin | input | 1 | Bin value |
| out_valid | output | 1 | Result registers hold a bin result |
| out_ready | input | 1 | Consumer takes the result |
| out_low | output | 10 | Renormalized low after the bin |
| out_range | output | 9 | Renormalized range after the bin |
| out_shift | output | 3 | Renormalization shift count |
| out_bits | output | 8 | Bits moved above bit 9 of low (carry first, then shifted bits) |

## Verification
The checker assumes that range never leaves [256, 511], which follows from the table minimum of 5. It also assumes that the consumer keeps `out_ready` meaningful each cycle, with no rule on when it may rise or fall. The stimulus climbs one context through every probability state with a leading LPS at state 0. It then mixes heavily colliding contexts, bypass runs, idle input cycles and random output back-pressure. Every bin is chosen from the bench's own model of the current MPS, so both coding paths are reached at every state.

// File: rtl/cabac_pkg.sv
// Shared widths, context entry type and table-generation functions.
// Assumes the LPS width table is built at elaboration from a fixed decay.
package cabac_pkg;
    localparam int RANGE_W   = 9;
    localparam int LOW_W     = 10;
    localparam int STATE_W   = 6;
    localparam int NSTATES   = 1 << STATE_W;
    localparam int TOP_STATE = 62;
    localparam int SH_W      = 3;
    localparam int MAX_SH    = 7;
    localparam int CAND_W    = 8;
    localparam int NQUART    = 4;
    localparam int WIDE_W    = LOW_W + 1 + MAX_SH;
    localparam int BITS_W    = WIDE_W - LOW_W;
    localparam int DECAY_Q16 = 62206;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic               mps;
    } ctx_t;

    // LPS width for probability state s in range quarter q.
    function automatic int lps_value(input int s, input int q);
        int p;
        p = 32768;
        for (int i = 0; i < s; i++) p = (p * DECAY_Q16) >>> 16;
        return (p * (288 + 64 * q)) >>> 16;
    endfunction

    // Successor state after an MPS bin.
    function automatic logic [STATE_W-1:0] next_on_mps(input logic [STATE_W-1:0] s);
        return (int'(s) >= TOP_STATE) ? STATE_W'(TOP_STATE) : s + 1'b1;
    endfunction

    // Successor state after an LPS bin.
    function automatic logic [STATE_W-1:0] next_on_lps(input logic [STATE_W-1:0] s);
        return s - STATE_W'((int'(s) + 3) / 4);
    endfunction
endpackage

// File: rtl/cabac_ctx_store.sv
// Context memory with one read and one write port per cycle.
// Assumes a write and a read of the same entry in one cycle must return
// the written value (forwarding into the read stage).
module cabac_ctx_store
    import cabac_pkg::*;
#(
    parameter int CTX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTX_W-1:0] rd_idx,
    output ctx_t             rd_ent,
    input  logic             wr_en,
    input  logic [CTX_W-1:0] wr_idx,
    input  ctx_t             wr_ent
);
    localparam int DEPTH = 1 << CTX_W;

    ctx_t mem [DEPTH];

    // Clear all entries on reset, then store write-backs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_ent;
        end
    end

    // Read with same-cycle write forwarding.
    always_comb begin
        rd_ent = (wr_en && (wr_idx == rd_idx)) ? wr_ent : mem[rd_idx];
    end
endmodule

// File: rtl/cabac_lps_rom.sv
// Probability tables: all four LPS width candidates and both successor
// states for one probability state. Range is not an input.
module cabac_lps_rom
    import cabac_pkg::*;
(
    input  logic [STATE_W-1:0]             state,
    output logic [NQUART-1:0][CAND_W-1:0]  cand,
    output logic [STATE_W-1:0]             nxt_mps,
    output logic [STATE_W-1:0]             nxt_lps
);
    logic [CAND_W-1:0] tab [NSTATES][NQUART];

    for (genvar s = 0; s < NSTATES; s++) begin : g_state
        for (genvar q = 0; q < NQUART; q++) begin : g_quart
            assign tab[s][q] = CAND_W'(lps_value(s, q));
        end
    end

    // Look up the candidate row and the successor states.
    always_comb begin
        for (int q = 0; q < NQUART; q++) cand[q] = tab[state][q];
        nxt_mps = next_on_mps(state);
        nxt_lps = next_on_lps(state);
    end
endmodule

// File: rtl/cabac_renorm.sv
// Range renormalizer: counts leading zeros of a nonzero 9-bit width and
// shifts it left so that its top bit is set. Assumes input >= 2.
module cabac_renorm
    import cabac_pkg::*;
(
    input  logic [RANGE_W-1:0] r_in,
    output logic [SH_W-1:0]    shift,
    output logic [RANGE_W-1:0] r_out
);
    // Highest set bit determines the leading-zero count.
    always_comb begin
        shift = SH_W'(MAX_SH);
        for (int i = 1; i < RANGE_W; i++) begin
            if (r_in[i]) shift = SH_W'(RANGE_W - 1 - i);
        end
        r_out = r_in << shift;
    end
endmodule

// File: rtl/cabac_pipe_coder.sv
// Four-stage binary arithmetic coder. Stage 0 reads context, stage 1 reads
// tables, stage 2 updates range and writes context back, stage 3 updates low.
// Assumes the consumer may deassert out_ready at any time; the whole
// pipeline then holds.
module cabac_pipe_coder
    import cabac_pkg::*;
#(
    parameter int CTX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_bypass,
    input  logic [CTX_W-1:0]   in_ctx,
    input  logic               in_bin,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [LOW_W-1:0]   out_low,
    output logic [RANGE_W-1:0] out_range,
    output logic [SH_W-1:0]    out_shift,
    output logic [BITS_W-1:0]  out_bits
);
    localparam logic [RANGE_W-1:0] RANGE_INIT = RANGE_W'(510);

    logic adv;

    // stage 0 -> 1 registers
    logic             v1, byp1, bin1;
    logic [CTX_W-1:0] ctx1;
    ctx_t             ent1, ent_rd, ent_use, wr_ent;
    logic             fwd1, wr_en;

    // stage 1 -> 2 registers
    logic                            v2, byp2, bin2;
    logic [CTX_W-1:0]                ctx2;
    ctx_t                            ent2;
    logic [NQUART-1:0][CAND_W-1:0]   cand2, cand_c;
    logic [STATE_W-1:0]              nm2, nl2, nm_c, nl_c;

    // stage 2 state and logic
    logic [RANGE_W-1:0] range_q, rlps, rmps, raw_rng, norm_rng, add_c;
    logic [SH_W-1:0]    sh_c, sh2;
    logic               hit;

    // stage 2 -> 3 registers
    logic               v3, byp3;
    logic [SH_W-1:0]    sh3;
    logic [RANGE_W-1:0] add3, rng3;

    // stage 3 state and logic
    logic [LOW_W-1:0]  low_q;
    logic [WIDE_W-1:0] wide;

    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    cabac_ctx_store #(.CTX_W(CTX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (in_ctx),
        .rd_ent (ent_rd),
        .wr_en  (wr_en),
        .wr_idx (ctx2),
        .wr_ent (wr_ent)
    );

    // Stage 1 forwarding from the entry being written back this cycle.
    always_comb begin
        fwd1    = v2 && !byp2 && (ctx2 == ctx1);
        ent_use = fwd1 ? wr_ent : ent1;
    end

    cabac_lps_rom u_rom (
        .state   (ent_use.state),
        .cand    (cand_c),
        .nxt_mps (nm_c),
        .nxt_lps (nl_c)
    );

    // Stage 2: candidate select, range update and context write-back value.
    always_comb begin
        hit          = (bin2 == ent2.mps);
        rlps         = RANGE_W'(cand2[range_q[RANGE_W-2 -: 2]]);
        rmps         = range_q - rlps;
        raw_rng      = byp2 ? range_q : (hit ? rmps : rlps);
        wr_ent.state = hit ? nm2 : nl2;
        wr_ent.mps   = (!hit && (ent2.state == '0)) ? ~ent2.mps : ent2.mps;
        wr_en        = adv && v2 && !byp2;
        if (byp2) add_c = bin2 ? range_q : '0;
        else      add_c = hit ? '0 : rmps;
        sh2          = byp2 ? SH_W'(1) : sh_c;
    end

    cabac_renorm u_renorm (
        .r_in  (raw_rng),
        .shift (sh_c),
        .r_out (norm_rng)
    );

    // Stage 3: low update and renormalization into the wide parsing value.
    always_comb begin
        if (byp3) wide = WIDE_W'({low_q, 1'b0}) + WIDE_W'(add3);
        else      wide = (WIDE_W'(low_q) + WIDE_W'(add3)) << sh3;
    end

    // Advance the stage-0 and stage-1 pipeline registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; byp1 <= 1'b0; bin1 <= 1'b0; ctx1 <= '0; ent1 <= '0;
            v2 <= 1'b0; byp2 <= 1'b0; bin2 <= 1'b0; ctx2 <= '0; ent2 <= '0;
            cand2 <= '0; nm2 <= '0; nl2 <= '0;
        end else if (adv) begin
            v1    <= in_valid;
            byp1  <= in_bypass;
            bin1  <= in_bin;
            ctx1  <= in_ctx;
            ent1  <= ent_rd;
            v2    <= v1;
            byp2  <= byp1;
            bin2  <= bin1;
            ctx2  <= ctx1;
            ent2  <= ent_use;
            cand2 <= cand_c;
            nm2   <= nm_c;
            nl2   <= nl_c;
        end
    end

    // Hold the range state and pass stage-2 results to stage 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_q <= RANGE_INIT;
            v3 <= 1'b0; byp3 <= 1'b0; sh3 <= '0; add3 <= '0; rng3 <= RANGE_INIT;
        end else if (adv) begin
            if (v2 && !byp2) range_q <= norm_rng;
            v3   <= v2;
            byp3 <= byp2;
            sh3  <= sh2;
            add3 <= add_c;
            rng3 <= byp2 ? range_q : norm_rng;
        end
    end

    // Hold the low state and load the output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= '0;
            out_valid <= 1'b0; out_low <= '0; out_range <= RANGE_INIT;
            out_shift <= '0; out_bits <= '0;
        end else if (adv) begin
            if (v3) low_q <= wide[LOW_W-1:0];
            out_valid <= v3;
            out_low   <= wide[LOW_W-1:0];
            out_range <= rng3;
            out_shift <= sh3;
            out_bits  <= wide[WIDE_W-1:LOW_W];
        end
    end
endmodule

// File: rtl/cabac_pipe_chk.sv
// Port-level checker for cabac_pipe_coder, attached with bind.
module cabac_pipe_chk #(
    parameter int RW = 9,
    parameter int LW = 10,
    parameter int SW = 3,
    parameter int BW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [LW-1:0] out_low,
    input logic [RW-1:0] out_range,
    input logic [SW-1:0] out_shift,
    input logic [BW-1:0] out_bits
);
    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> !out_valid); // R1
    AST_RANGE_NORM: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> out_range[RW-1]); // R7
    AST_BITS_FIT: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> ((out_bits >> out_shift) <= BW'(1))); // R8
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |-> !in_ready); // R10
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_low) && $stable(out_range) && $stable(out_shift) && $stable(out_bits))); // R10
endmodule

bind cabac_pipe_coder cabac_pipe_chk #(
    .RW(cabac_pkg::RANGE_W), .LW(cabac_pkg::LOW_W),
    .SW(cabac_pkg::SH_W),    .BW(cabac_pkg::BITS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_low   (out_low),
    .out_range (out_range),
    .out_shift (out_shift),
    .out_bits  (out_bits)
);

// File: tb/cabac_pipe_coder_test.sv
// Self-checking bench: an arithmetic model built from the requirements
// predicts every output of the coder.
module cabac_pipe_coder_test;
    localparam int CLK_PERIOD = 10;
    localparam int CTX_W      = 4;
    localparam int NCTX       = 1 << CTX_W;
    localparam int N_A        = 150;
    localparam int N_B        = 1800;
    localparam int TOTAL      = 2600;
    localparam int QD         = 4096;
    localparam int WD_LIMIT   = 100000;

    logic clk, rst_n;
    logic in_valid, in_ready, in_bypass, in_bin, out_valid, out_ready;
    logic [CTX_W-1:0] in_ctx;
    logic [9:0] out_low;
    logic [8:0] out_range;
    logic [2:0] out_shift;
    logic [7:0] out_bits;

    cabac_pipe_coder #(.CTX_W(CTX_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_bypass(in_bypass),
        .in_ctx(in_ctx), .in_bin(in_bin),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_low(out_low), .out_range(out_range),
        .out_shift(out_shift), .out_bits(out_bits)
    );

    int nchk = 0, nfail = 0, cyc = 0;

    // model state
    int m_range, m_low;
    int m_st [NCTX];
    int m_mps [NCTX];
    int h_ctx1, h_ctx2;
    bit h_byp1, h_byp2;

    // expected results
    int    e_low [QD], e_rng [QD], e_sh [QD], e_bits [QD], e_cyc [QD];
    bit    e_byp [QD];
    string e_rtag [QD];

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: an expired run counts as a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc >= WD_LIMIT) begin
                nchk++; nfail++;
                $display("FAIL watchdog: run did not finish (act=%0d exp<%0d)", cyc, WD_LIMIT);
                $display("%0d/%0d checks passed", nchk - nfail, nchk);
                $finish;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
        end
    endtask

    function automatic int ref_lps(input int s, input int q);
        int p = 32768;
        for (int i = 0; i < s; i++) p = (p * 62206) / 65536;
        return (p * (288 + 64 * q)) / 65536;
    endfunction

    function automatic logic [31:0] lfsr(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    // Apply one accepted bin to the model and queue the expected result.
    task automatic model_bin(input bit byp, input int c, input bit b, input int idx);
        int wide, sh, add, s, rl, rm, nr;
        string tag;
        sh = 0;
        if (byp) begin
            wide = 2 * m_low + (b ? m_range : 0);
            sh = 1;
            tag = "R6";
        end else begin
            s  = m_st[c];
            rl = ref_lps(s, (m_range >> 6) & 3);
            rm = m_range - rl;
            if (b == m_mps[c][0]) begin
                nr = rm; add = 0;
                m_st[c] = (s >= 62) ? 62 : s + 1;
                tag = "R3";
            end else begin
                nr = rl; add = rm;
                if (s == 0) m_mps[c] = 1 - m_mps[c];
                m_st[c] = s - (s + 3) / 4;
                tag = "R4";
            end
            if ((!h_byp1 && h_ctx1 == c) || (!h_byp2 && h_ctx2 == c)) tag = "R9";
            while (nr < 256) begin nr = nr * 2; sh++; end
            m_range = nr;
            wide = (m_low + add) << sh;
        end
        if (idx == 0) tag = "R1";
        m_low = wide % 1024;
        e_low[idx] = m_low; e_rng[idx] = m_range; e_sh[idx] = sh;
        e_bits[idx] = wide / 1024; e_byp[idx] = byp; e_cyc[idx] = cyc;
        e_rtag[idx] = tag;
        h_ctx2 = h_ctx1; h_byp2 = h_byp1;
        h_ctx1 = c;      h_byp1 = byp;
    endtask

    initial begin
        logic [31:0] rs;
        int issued, rd;
        bit stalled_prev, any_stall;
        int sv_low, sv_rng, sv_sh, sv_bits;
        int c;

        rs = 32'h1ACE_5EED;
        issued = 0; rd = 0; stalled_prev = 0; any_stall = 0;
        sv_low = 0; sv_rng = 0; sv_sh = 0; sv_bits = 0;
        m_range = 510; m_low = 0;
        h_ctx1 = -1; h_ctx2 = -1; h_byp1 = 1; h_byp2 = 1;
        for (int i = 0; i < NCTX; i++) begin m_st[i] = 0; m_mps[i] = 0; end

        rst_n = 1'b0; in_valid = 1'b0; in_bypass = 1'b0; in_ctx = '0;
        in_bin = 1'b0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

        while (issued < TOTAL || rd != issued) begin
            @(negedge clk);
            rs = lfsr(rs);
            if (issued >= TOTAL) begin
                in_valid = 1'b0; out_ready = 1'b1;
            end else if (issued < N_A) begin
                // one context climbing through every state, leading LPS at state 0
                in_valid = 1'b1; out_ready = 1'b1; in_bypass = 1'b0; in_ctx = '0;
                in_bin = (issued == 0) ? ~m_mps[0][0] : m_mps[0][0];
            end else if (issued < N_B) begin
                // four colliding contexts, some bypass, back-pressure
                in_valid  = rs[0] | rs[1];
                out_ready = rs[2] | rs[3];
                c = int'(rs[5:4]);
                in_ctx    = CTX_W'(c);
                in_bypass = (rs[8:6] == 3'd0);
                in_bin    = in_bypass ? rs[12] : ((rs[11:9] == 3'd0) ? ~m_mps[c][0] : m_mps[c][0]);
            end else begin
                // all contexts, long bypass share
                in_valid  = rs[0];
                out_ready = rs[2] | rs[3] | rs[4];
                c = int'(rs[7:4]);
                in_ctx    = CTX_W'(c);
                in_bypass = rs[9];
                in_bin    = in_bypass ? rs[13] : ((rs[12:10] < 3'd3) ? ~m_mps[c][0] : m_mps[c][0]);
            end
            #1;
            if (!out_ready) any_stall = 1;
            if (stalled_prev) begin
                chk(out_valid == 1'b1, "R10 valid held", int'(out_valid), 1);
                chk(int'(out_low) == sv_low && int'(out_range) == sv_rng &&
                    int'(out_shift) == sv_sh && int'(out_bits) == sv_bits,
                    "R10 outputs held (low)", int'(out_low), sv_low);
            end
            if (issued < N_A && issued > 0)
                chk(in_ready == 1'b1, "R2 accepts every cycle", int'(in_ready), 1);
            if (out_valid && !out_ready) begin
                chk(in_ready == 1'b0, "R10 input blocked", int'(in_ready), 0);
                stalled_prev = 1;
                sv_low = int'(out_low); sv_rng = int'(out_range);
                sv_sh = int'(out_shift); sv_bits = int'(out_bits);
            end else begin
                stalled_prev = 0;
            end
            if (out_valid && out_ready) begin
                if (rd >= issued) begin
                    chk(1'b0, "R2 unexpected output", rd, issued);
                end else begin
                    chk(int'(out_range) == e_rng[rd], e_rtag[rd], int'(out_range), e_rng[rd]);
                    chk(int'(out_low) == e_low[rd], e_byp[rd] ? "R6 low" : "R5 low", int'(out_low), e_low[rd]);
                    chk(int'(out_shift) == e_sh[rd], e_byp[rd] ? "R6 shift" : "R7 shift", int'(out_shift), e_sh[rd]);
                    chk(int'(out_bits) == e_bits[rd], "R8 bits", int'(out_bits), e_bits[rd]);
                    if (!any_stall)
                        chk(cyc - e_cyc[rd] == 4, "R2 latency", cyc - e_cyc[rd], 4);
                    rd++;
                end
            end
            if (in_valid && in_ready && issued < TOTAL) begin
                model_bin(in_bypass, int'(in_ctx), in_bin, issued);
                issued++;
            end
        end
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 drained", int'(out_valid), 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule